// File: doc/BRIEF.md
# Bonded GPIO Port with Peripheral Pin Takeover

This block controls an 8-bit general-purpose I/O port through a small register interface. Three registers are kept: a port value register, a per-pin direction register and a control register that holds one port-wide pull-up switch and one port-wide reduced-drive switch. From these the block produces per-pin output-enable, output-value, pull-up and drive-strength lines for the pad ring. Pin levels coming back from the pads are synchronised before software can read them.

Only pins 6 down to 2 are bonded to pads; every pad line for the other bits is held low. A peripheral with four channels (for example a pulse-width generator) can claim pins 2 to 5 one by one through its enable vector. A claimed pin is driven by the peripheral regardless of the GPIO direction and value, and it never gets a pull-up. Reading the port returns the stored value for pins set as outputs and the synchronised pad level for bonded input pins. Bit 7 has its own rule: it reads as zero unless its direction bit is set.

The register port uses a single write strobe with an address and a combinational read path, with no wait states.

Top module: `gpio_port`

## Requirements
- R1: After reset the value, direction and control registers read 0 and every bit of pad_oe, pad_do, pad_pu and pad_rd is 0.
- R2: A bonded, unclaimed pin whose direction bit is 1 has pad_oe=1 and pad_do equal to its value-register bit. With direction bit 0 it has pad_oe=0 and pad_do=0.
- R3: At address 0, read bit 7 is 0 when direction bit 7 is 0, and it equals stored value bit 7 when direction bit 7 is 1.
- R4: At address 0, read bits 6..2 return the value-register bit for output pins. For input pins they return pad_di, delayed through exactly two clock edges.
- R5: Unbonded bits 7, 1 and 0 never drive pad_oe, pad_do, pad_pu or pad_rd. Read bits 1 and 0 at address 0 are always 0.
- R6: With control bit 0 (pull-up) set, pad_pu is 1 on exactly those bonded pins whose pad_oe is 0. With it clear, pad_pu is 0.
- R7: With control bit 1 (reduced drive) set, pad_rd is 1 on exactly those bonded pins whose pad_oe is 1. With it clear, pad_rd is 0.
- R8: Address 1 reads the full direction register. Address 2 reads {6'b0, reduced-drive, pull-up}. Both registers can be written at any time after reset.
- R9: When per_en[k] is 1, pin k+2 has pad_oe=1 and pad_do=per_out[k], whatever its direction and value bits say.
- R10: Writes to the value register are stored while the pin is an input or is claimed. The stored value appears on pad_do once the pin is an unclaimed output.
- R11: A write to address 3 changes no register, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 value, 1 direction, 2 control, 3 unused |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for reg_addr |
| per_en | input | 4 | Peripheral claim per channel; channel k owns pin k+2 |
| per_out | input | 4 | Peripheral drive value per channel |
| pad_di | input | 8 | Pad input levels |
| pad_oe | output | 8 | Pad output enable per pin |
| pad_do | output | 8 | Pad output value per pin |
| pad_pu | output | 8 | Pad pull-up enable per pin |
| pad_rd | output | 8 | Pad reduced-drive select per pin |

## Verification
A peripheral claim and a GPIO value write can take effect in the same cycle. The bench writes the value register while per_en holds the same pin, then sets the pin as an output. It checks that the pad follows per_out during the claim and shows the freshly stored value once the claim is released. Direction changes and pad-level changes also meet in the read path. A full sweep of all 256 direction patterns, each with its own pad input, value and control setting, compares every pad vector and the read-back against values computed arithmetically from the requirements.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    typedef enum logic [1:0] {
        ADR_VALUE = 2'd0,
        ADR_DIR   = 2'd1,
        ADR_CTRL  = 2'd2,
        ADR_NONE  = 2'd3
    } gpio_addr_e;

    typedef struct packed {
        logic low_drive;
        logic pull_en;
    } gpio_ctrl_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
            dout    <= '0;
        end else begin
            stage_q <= din;
            dout    <= stage_q;
        end
    end

    // R4: the output is the input from two edges earlier
    a_r4_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n, 2) |-> dout == $past(din, 2));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int          WIDTH     = 8,
    parameter logic [7:0]  BOND_MASK = 8'h7C,
    parameter int          TOP_BIT   = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [1:0]       reg_addr,
    input  logic [WIDTH-1:0] reg_wdata,
    output logic [WIDTH-1:0] reg_rdata,
    input  logic [WIDTH-1:0] pin_sync,
    output logic [WIDTH-1:0] value_q,
    output logic [WIDTH-1:0] dir_q,
    output gpio_ctrl_t       ctrl_q
);
    localparam logic [WIDTH-1:0] BOND   = BOND_MASK[WIDTH-1:0];
    localparam logic [WIDTH-1:0] TOPSEL = WIDTH'(1) << TOP_BIT;
    localparam logic [WIDTH-1:0] RDMASK = BOND | TOPSEL;

    gpio_addr_e addr;
    assign addr = gpio_addr_e'(reg_addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value_q <= '0;
            dir_q   <= '0;
            ctrl_q  <= '0;
        end else if (reg_we) begin
            unique case (addr)
                ADR_VALUE: value_q <= reg_wdata;
                ADR_DIR:   dir_q   <= reg_wdata;
                ADR_CTRL:  ctrl_q  <= '{low_drive: reg_wdata[1], pull_en: reg_wdata[0]};
                ADR_NONE:  ;
            endcase
        end
    end

    always_comb begin
        unique case (addr)
            ADR_VALUE: reg_rdata = (dir_q & value_q & RDMASK) | (~dir_q & pin_sync & BOND);
            ADR_DIR:   reg_rdata = dir_q;
            ADR_CTRL:  reg_rdata = {{(WIDTH-2){1'b0}}, ctrl_q.low_drive, ctrl_q.pull_en};
            ADR_NONE:  reg_rdata = '0;
        endcase
    end

    // R10: value writes always land, whatever the pin state
    a_r10_value_store: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 2'd0) |=> value_q == $past(reg_wdata));
    // R11: address 3 leaves all registers alone
    a_r11_hole_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 2'd3) |=> ($stable(value_q) && $stable(dir_q) && $stable(ctrl_q)));
    // R3: top bit hidden while its direction bit is clear
    a_r3_top_hidden: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd0 && !dir_q[TOP_BIT]) |-> !reg_rdata[TOP_BIT]);
endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl
    import gpio_pkg::*;
#(
    parameter int         WIDTH     = 8,
    parameter logic [7:0] BOND_MASK = 8'h7C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] value_q,
    input  logic [WIDTH-1:0] dir_q,
    input  gpio_ctrl_t       ctrl_q,
    input  logic [WIDTH-1:0] claim,
    input  logic [WIDTH-1:0] claim_val,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_do,
    output logic [WIDTH-1:0] pad_pu,
    output logic [WIDTH-1:0] pad_rd
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        if (BOND_MASK[i]) begin : g_bonded
            logic drive;
            assign drive     = claim[i] | dir_q[i];
            assign pad_oe[i] = drive;
            assign pad_do[i] = claim[i] ? claim_val[i] : (dir_q[i] & value_q[i]);
            assign pad_pu[i] = ctrl_q.pull_en & ~drive;
            assign pad_rd[i] = ctrl_q.low_drive & drive;

            // R6: no pull-up on a driven pin
            a_r6_pu_idle: assert property (@(posedge clk) disable iff (!rst_n)
                pad_pu[i] |-> !pad_oe[i]);
        end else begin : g_unbonded
            assign pad_oe[i] = 1'b0;
            assign pad_do[i] = 1'b0;
            assign pad_pu[i] = 1'b0;
            assign pad_rd[i] = 1'b0;
        end
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int         WIDTH     = 8,
    parameter logic [7:0] BOND_MASK = 8'h7C,
    parameter int         TOP_BIT   = 7,
    parameter int         PER_CH    = 4,
    parameter int         PER_LSB   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [WIDTH-1:0]  reg_wdata,
    output logic [WIDTH-1:0]  reg_rdata,
    input  logic [PER_CH-1:0] per_en,
    input  logic [PER_CH-1:0] per_out,
    input  logic [WIDTH-1:0]  pad_di,
    output logic [WIDTH-1:0]  pad_oe,
    output logic [WIDTH-1:0]  pad_do,
    output logic [WIDTH-1:0]  pad_pu,
    output logic [WIDTH-1:0]  pad_rd
);
    localparam logic [WIDTH-1:0] BOND = BOND_MASK[WIDTH-1:0];

    logic [WIDTH-1:0] pin_sync, value_q, dir_q, claim, claim_val;
    gpio_ctrl_t       ctrl_q;

    always_comb begin
        claim     = '0;
        claim_val = '0;
        for (int k = 0; k < PER_CH; k++) begin
            claim[PER_LSB+k]     = per_en[k];
            claim_val[PER_LSB+k] = per_out[k];
        end
    end

    gpio_sync #(.WIDTH(WIDTH)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(pad_di & BOND), .dout(pin_sync)
    );

    gpio_regs #(.WIDTH(WIDTH), .BOND_MASK(BOND_MASK), .TOP_BIT(TOP_BIT)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_sync(pin_sync),
        .value_q(value_q), .dir_q(dir_q), .ctrl_q(ctrl_q)
    );

    gpio_pad_ctl #(.WIDTH(WIDTH), .BOND_MASK(BOND_MASK)) u_pads (
        .clk(clk), .rst_n(rst_n), .value_q(value_q), .dir_q(dir_q), .ctrl_q(ctrl_q),
        .claim(claim), .claim_val(claim_val),
        .pad_oe(pad_oe), .pad_do(pad_do), .pad_pu(pad_pu), .pad_rd(pad_rd)
    );

    // R5: unbonded pins stay quiet
    a_r5_unbonded: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe | pad_do | pad_pu | pad_rd) & ~BOND) == '0);
    // R9: a claimed pin is always driven
    a_r9_claim_drives: assert property (@(posedge clk) disable iff (!rst_n)
        per_en[0] |-> pad_oe[PER_LSB]);
    // R1: registers come out of reset cleared
    a_r1_reset_dir: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dir_q == '0 && value_q == '0));
endmodule

// File: tb/gpio_port_bench.sv
module gpio_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic [3:0] per_en = 4'd0;
    logic [3:0] per_out = 4'd0;
    logic [7:0] pad_di = 8'd0;
    logic [7:0] pad_oe, pad_do, pad_pu, pad_rd;

    int tests = 0;
    int fails = 0;
    localparam logic [7:0] BOND = 8'h7C;

    always #2.5 clk = ~clk;

    gpio_port u_gpio_port (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .per_en(per_en),
        .per_out(per_out), .pad_di(pad_di), .pad_oe(pad_oe), .pad_do(pad_do),
        .pad_pu(pad_pu), .pad_rd(pad_rd)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic check_pads(input string req, input logic [7:0] dir, input logic [7:0] val,
                              input logic [1:0] ctl);
        logic [7:0] own, ownv, oe, dout, pu, rdv;
        own  = {2'b00, per_en, 2'b00};
        ownv = {2'b00, per_out, 2'b00};
        oe   = BOND & (own | dir);
        dout = BOND & ((own & ownv) | (~own & dir & val));
        pu   = BOND & {8{ctl[0]}} & ~oe;
        rdv  = BOND & {8{ctl[1]}} & oe;
        check(req, {pad_oe, pad_do, pad_pu, pad_rd}, {oe, dout, pu, rdv});
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] r, dir, val, pin, expr;
        logic [1:0] ctl;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 pads", {pad_oe, pad_do, pad_pu, pad_rd}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(2'd1, r); check("R1 dir", r, 8'd0);
        rd(2'd2, r); check("R1 ctrl", r, 8'd0);
        rd(2'd0, r); check("R1 value", r, 8'd0);

        // R2 R3 R4 R5 R6 R7 R8: sweep every direction pattern
        for (int i = 0; i < 256; i++) begin
            dir = 8'(i);
            val = dir ^ 8'h5A ^ 8'(i * 7);
            pin = 8'hA5 ^ 8'(i * 13);
            ctl = 2'(i);
            pad_di = pin;
            wr(2'd1, dir);
            wr(2'd0, val);
            wr(2'd2, {6'b111111, ctl});
            @(negedge clk);
            check_pads("R2/R5/R6/R7 sweep", dir, val, ctl);
            expr = (dir & val & 8'hFC) | (~dir & pin & BOND);
            rd(2'd0, r); check("R3/R4 readback", r, expr);
            rd(2'd2, r); check("R8 ctrl read", r, {6'b0, ctl});
            rd(2'd1, r); check("R8 dir read", r, dir);
        end

        // R9: every claim pattern with every peripheral value
        wr(2'd2, 8'h03);
        for (int e = 0; e < 16; e++) begin
            for (int o = 0; o < 16; o++) begin
                per_en = 4'(e); per_out = 4'(o);
                dir = 8'(e * 37 + o); val = 8'(o * 91);
                wr(2'd1, dir);
                wr(2'd0, val);
                check_pads("R9 claim", dir, val, 2'b11);
            end
        end
        per_en = 4'd0;

        // R4: exact two-edge latency of the pad sampler
        wr(2'd1, 8'h00);
        pad_di = 8'h00;
        repeat (3) @(negedge clk);
        pad_di = 8'h7C;
        @(negedge clk);
        rd(2'd0, r); check("R4 one edge", r, 8'h00);
        @(negedge clk);
        rd(2'd0, r); check("R4 two edges", r, 8'h7C);

        // R10: value written during claim appears after release
        wr(2'd2, 8'h00);
        wr(2'd1, 8'h00);
        per_en = 4'b0010; per_out = 4'b0000;
        wr(2'd0, 8'h08);
        check("R10 claimed pin", {pad_oe[3], pad_do[3]}, 2'b10);
        wr(2'd1, 8'h08);
        check("R10 still claimed", {pad_oe[3], pad_do[3]}, 2'b10);
        per_en = 4'd0;
        #1;
        check("R10 released", {pad_oe[3], pad_do[3]}, 2'b11);

        // R11: address 3 is a hole
        wr(2'd3, 8'hFF);
        rd(2'd3, r); check("R11 read", r, 8'h00);
        rd(2'd1, r); check("R11 dir kept", r, 8'h08);
        rd(2'd2, r); check("R11 ctrl kept", r, 8'h00);
        check("R11 pads kept", {pad_oe, pad_do}, {8'h08, 8'h08});

        // R3: bit 7 with direction set
        wr(2'd1, 8'h80);
        wr(2'd0, 8'h80);
        rd(2'd0, r); check("R3 top set", r[7], 1'b1);
        check("R5 top no drive", pad_oe[7], 1'b0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule